// File: doc/BRIEF.md
# Asynchronous SRAM / NOR Flash Bus Sequencer

This block drives the external memory bus for up to three asynchronous devices, such as plain SRAM or NOR flash. Each device sits on its own active-low chip select. A small 32-bit configuration space holds two words per chip select. The mode word turns on a ready (wait) handshake and a NOR page-read burst, and it stores a bus-width code. The timing word holds four cycle counts: first-read address cycles, read address cycles, read strobe cycles and write strobe cycles.

Internal requests arrive on a valid/ready port. Each request carries a chip-select index, a byte address, a write flag and write data. The sequencer turns each request into an address phase, then a strobe phase, then the release of the chip select. Each word read is returned with a one-cycle valid pulse. A page read reads sequential words with the strobe held low and stops after the last word before a 16-byte boundary. When ready mode is on, a slow peripheral can hold the strobe off by pulling the ready pin low.

Top module: `ebc_ctrl`

## Requirements
- R1: Mode words sit at byte offsets 0x00, 0x08 and 0x10 and timing words at 0x04, 0x0C and 0x14, for chip selects 0, 1 and 2. All of them are 0 after reset. `cfg_rdata` shows the word addressed by `cfg_addr` one clock later.
- R2: Mode word fields are bit 6 = ready mode enable, bit 5 = page read enable and bits 1:0 = width code. Timing word fields are bits 3:0 = first-read address count, 7:4 = read address count, 11:8 = read strobe count and 15:12 = write strobe count. Every other bit is not stored and reads as 0.
- R3: A configuration write takes effect only when `cfg_addr[1:0]` is 0 and the offset is one of the six words above. Any other write leaves all words unchanged.
- R4: A single read asserts `mem_cs_n[cs]` low. It then holds both strobes high for (read address count + 1) cycles, and then holds `mem_rd_n` low for (read strobe count + 1) cycles. It returns exactly one `rd_valid` pulse with the word read on the last strobe cycle, and it releases the chip select on that same cycle.
- R5: A write has an address phase of (read address count + 1) cycles, followed by `mem_wr_n` low for (write strobe count + 1) cycles. During the strobe, `mem_addr` and `mem_dout` equal the request's address and data. A write is always a single access, even when page read is enabled.
- R6: When page read is enabled and the read address count is 0, a read has an address phase of (first-read address count + 1) cycles. It then reads words at address, address+4 and so on. Each word takes (read strobe count + 1) cycles, with `mem_rd_n` kept low and no new address phase. The burst ends after the word with address bits 3:2 = 3. Every word gives one `rd_valid` pulse.
- R7: When page read is enabled but the read address count is nonzero, a read is a single access, timed as in R4.
- R8: With ready mode off, `mem_rdy` has no effect. Held low, it leaves the address phase at exactly the programmed length.
- R9: With ready mode on, `mem_rdy` passes through a two-flop synchronizer. While the synchronized level is low during the last two address-phase cycles, the strobe stays high. After release, the strobe begins within (address count + 3) cycles. With `mem_rdy` high, timing is as in R4 and R5.
- R10: At most one chip select is low at a time. The two strobes are never low together, and a strobe is low only while a chip select is low. `req_ready` is high only when no chip select is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | CFG_AW | Configuration byte offset |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data, one cycle after address |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Sequencer idle and accepting |
| req_cs | input | CSW | Chip-select index of the request |
| req_addr | input | AW | Byte address of the request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DW | Write data |
| rd_valid | output | 1 | One-cycle pulse per returned read word |
| rd_data | output | DW | Returned read word |
| mem_cs_n | output | NCS | Active-low chip selects |
| mem_rd_n | output | 1 | Active-low read strobe |
| mem_wr_n | output | 1 | Active-low write strobe |
| mem_addr | output | AW | External address |
| mem_dout | output | DW | External write data |
| mem_din | input | DW | External read data |
| mem_rdy | input | 1 | Asynchronous ready from peripheral, low = wait |

## Verification
The assertions check bus exclusivity on every cycle: one chip select at most, no overlapping strobes, and no strobe without a select. They also check that a page burst never steps across a 16-byte boundary. With ready mode off, the address phase must end on its programmed final count. With ready mode on, a low synchronized ready must hold the strobe off. Exact phase lengths, returned data, word counts per burst, the page fallback, and register masking and aligned-write filtering can only be shown by the bench. It sweeps every count combination in a small range and every start word of a page.

// File: rtl/ebc_pkg.sv
package ebc_pkg;
  localparam int CNT_W = 4;

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_STRB} seq_st_t;

  typedef struct packed {
    logic       rdy_en;
    logic       page_en;
    logic [1:0] width;
  } mode_t;

  typedef struct packed {
    logic [CNT_W-1:0] wacc;
    logic [CNT_W-1:0] racc;
    logic [CNT_W-1:0] ra;
    logic [CNT_W-1:0] fra;
  } tim_t;
endpackage

// File: rtl/ebc_regs.sv
module ebc_regs
  import ebc_pkg::*;
#(
  parameter int NCS    = 3,
  parameter int CFG_AW = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfg_we,
  input  logic [CFG_AW-1:0]     cfg_addr,
  input  logic [31:0]           cfg_wdata,
  output logic [31:0]           cfg_rdata,
  output mode_t [NCS-1:0]       mode_o,
  output tim_t  [NCS-1:0]       tim_o
);
  localparam int IDXW = CFG_AW - 3;

  logic [IDXW-1:0] idx;
  logic            is_tim;
  logic            aligned;
  logic [31:0]     rd_mux;

  assign idx     = cfg_addr[CFG_AW-1:3];
  assign is_tim  = cfg_addr[2];
  assign aligned = (cfg_addr[1:0] == 2'b00);

  for (genvar g = 0; g < NCS; g++) begin : g_cs
    always_ff @(posedge clk) begin
      if (rst) begin
        mode_o[g] <= '0;
        tim_o[g]  <= '0;
      end else if (cfg_we && aligned && idx == IDXW'(g)) begin
        if (!is_tim) begin
          mode_o[g].rdy_en  <= cfg_wdata[6];
          mode_o[g].page_en <= cfg_wdata[5];
          mode_o[g].width   <= cfg_wdata[1:0];
        end else begin
          tim_o[g] <= cfg_wdata[$bits(tim_t)-1:0];
        end
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NCS; i++) begin
      if (idx == IDXW'(i)) begin
        if (is_tim) rd_mux = 32'(tim_o[i]);
        else rd_mux = {25'd0, mode_o[i].rdy_en, mode_o[i].page_en, 3'd0, mode_o[i].width};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_rdata <= '0;
    else     cfg_rdata <= rd_mux;
  end

  // R2: unstored bits never appear on the read port
  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (rst)
    cfg_rdata[31:16] == 16'd0);

  // R3: a misaligned write leaves every word untouched
  p_misaligned_ignored_r3: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && !aligned) |=> ($stable(mode_o) && $stable(tim_o)));
endmodule

// File: rtl/ebc_sync.sv
module ebc_sync #(
  parameter int   STAGES = 2,
  parameter logic INIT   = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= {STAGES{INIT}};
    else     sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/ebc_seq.sv
module ebc_seq
  import ebc_pkg::*;
#(
  parameter int NCS = 3,
  parameter int CSW = 2,
  parameter int AW  = 24,
  parameter int DW  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [CSW-1:0]    req_cs,
  input  logic [AW-1:0]     req_addr,
  input  logic              req_we,
  input  logic [DW-1:0]     req_wdata,
  input  mode_t [NCS-1:0]   mode_i,
  input  tim_t  [NCS-1:0]   tim_i,
  input  logic              rdy_s,
  input  logic [DW-1:0]     mem_din,
  output logic              rd_valid,
  output logic [DW-1:0]     rd_data,
  output logic [NCS-1:0]    mem_cs_n,
  output logic              mem_rd_n,
  output logic              mem_wr_n,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_dout
);
  seq_st_t          st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CSW-1:0]   cs_q;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    wdata_q;
  logic             we_q, page_q, rdy_en_q;
  logic [CNT_W-1:0] racc_q, wacc_q;
  mode_t            sel_mode;
  tim_t             sel_tim;
  logic             stall;
  logic             last_word;

  always_comb begin
    sel_mode = '0;
    sel_tim  = '0;
    for (int i = 0; i < NCS; i++) begin
      if (req_cs == CSW'(i)) begin
        sel_mode = mode_i[i];
        sel_tim  = tim_i[i];
      end
    end
  end

  // Wait window: the final two address cycles before the strobe
  assign stall     = rdy_en_q && !rdy_s && (cnt_q <= CNT_W'(1));
  assign last_word = !page_q || (addr_q[3:2] == 2'b11);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= S_IDLE;
      cnt_q    <= '0;
      cs_q     <= '0;
      addr_q   <= '0;
      wdata_q  <= '0;
      we_q     <= 1'b0;
      page_q   <= 1'b0;
      rdy_en_q <= 1'b0;
      racc_q   <= '0;
      wacc_q   <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= 1'b0;
      unique case (st_q)
        S_IDLE: if (req_valid) begin
          cs_q     <= req_cs;
          addr_q   <= req_addr;
          wdata_q  <= req_wdata;
          we_q     <= req_we;
          page_q   <= !req_we && sel_mode.page_en && (sel_tim.ra == '0);
          rdy_en_q <= sel_mode.rdy_en;
          racc_q   <= sel_tim.racc;
          wacc_q   <= sel_tim.wacc;
          cnt_q    <= (!req_we && sel_mode.page_en && sel_tim.ra == '0) ? sel_tim.fra : sel_tim.ra;
          st_q     <= S_ADDR;
        end
        S_ADDR: if (!stall) begin
          if (cnt_q == '0) begin
            cnt_q <= we_q ? wacc_q : racc_q;
            st_q  <= S_STRB;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        S_STRB: begin
          if (cnt_q == '0) begin
            if (!we_q) begin
              rd_valid <= 1'b1;
              rd_data  <= mem_din;
            end
            if (last_word) begin
              st_q <= S_IDLE;
            end else begin
              addr_q <= addr_q + AW'(4);
              cnt_q  <= racc_q;
            end
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (st_q == S_IDLE);
  assign mem_rd_n  = !(st_q == S_STRB && !we_q);
  assign mem_wr_n  = !(st_q == S_STRB && we_q);
  assign mem_addr  = addr_q;
  assign mem_dout  = wdata_q;

  for (genvar g = 0; g < NCS; g++) begin : g_csn
    assign mem_cs_n[g] = !(st_q != S_IDLE && cs_q == CSW'(g));
  end

  // R10: bus exclusivity
  p_cs_onehot_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~mem_cs_n));
  p_strb_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(!mem_rd_n && !mem_wr_n));
  p_strb_needs_cs_r10: assert property (@(posedge clk) disable iff (rst)
    (!mem_rd_n || !mem_wr_n) |-> (mem_cs_n != '1));

  // R6: a page burst never advances across a 16-byte boundary
  p_page_boundary_r6: assert property (@(posedge clk) disable iff (rst)
    (!mem_rd_n && $past(!mem_rd_n) && mem_addr != $past(mem_addr)) |-> (mem_addr[3:2] != 2'b00));

  // R8: with ready mode off the last address count always leads to the strobe
  p_ready_off_r8: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_ADDR && !rdy_en_q && cnt_q == '0) |=> (st_q == S_STRB));

  // R9: a low synchronized ready in the window keeps strobes high
  p_ready_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_ADDR && rdy_en_q && !rdy_s && cnt_q <= CNT_W'(1)) |=> (mem_rd_n && mem_wr_n));

  // R4: a returned word always follows a read strobe cycle
  p_rvalid_src_r4: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(!mem_rd_n));
endmodule

// File: rtl/ebc_ctrl.sv
module ebc_ctrl
  import ebc_pkg::*;
#(
  parameter int NCS    = 3,
  parameter int CSW    = (NCS > 1) ? $clog2(NCS) : 1,
  parameter int CFG_AW = 5,
  parameter int AW     = 24,
  parameter int DW     = 32,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [CSW-1:0]    req_cs,
  input  logic [AW-1:0]     req_addr,
  input  logic              req_we,
  input  logic [DW-1:0]     req_wdata,
  output logic              rd_valid,
  output logic [DW-1:0]     rd_data,
  output logic [NCS-1:0]    mem_cs_n,
  output logic              mem_rd_n,
  output logic              mem_wr_n,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_dout,
  input  logic [DW-1:0]     mem_din,
  input  logic              mem_rdy
);
  mode_t [NCS-1:0] mode_w;
  tim_t  [NCS-1:0] tim_w;
  logic            rdy_s;

  ebc_regs #(.NCS(NCS), .CFG_AW(CFG_AW)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .mode_o(mode_w), .tim_o(tim_w)
  );

  ebc_sync #(.STAGES(SYNC_N), .INIT(1'b1)) u_sync (
    .clk(clk), .rst(rst), .d(mem_rdy), .q(rdy_s)
  );

  ebc_seq #(.NCS(NCS), .CSW(CSW), .AW(AW), .DW(DW)) u_seq (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_cs(req_cs),
    .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata),
    .mode_i(mode_w), .tim_i(tim_w), .rdy_s(rdy_s), .mem_din(mem_din),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .mem_cs_n(mem_cs_n), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
    .mem_addr(mem_addr), .mem_dout(mem_dout)
  );
endmodule

// File: tb/ebc_ctrl_test.sv
`timescale 1ns/1ps
module ebc_ctrl_test;
  localparam int NCS = 3, CSW = 2, CFG_AW = 5, AW = 24, DW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic              cfg_we = 1'b0;
  logic [CFG_AW-1:0] cfg_addr = '0;
  logic [31:0]       cfg_wdata = '0;
  logic [31:0]       cfg_rdata;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [CSW-1:0]    req_cs = '0;
  logic [AW-1:0]     req_addr = '0;
  logic              req_we = 1'b0;
  logic [DW-1:0]     req_wdata = '0;
  logic              rd_valid;
  logic [DW-1:0]     rd_data;
  logic [NCS-1:0]    mem_cs_n;
  logic              mem_rd_n, mem_wr_n;
  logic [AW-1:0]     mem_addr;
  logic [DW-1:0]     mem_dout;
  logic [DW-1:0]     mem_din;
  logic              mem_rdy = 1'b1;

  assign mem_din = 32'hA500_0000 | {8'h00, mem_addr};

  ebc_ctrl uut (.*);

  int errs = 0, checks = 0;
  bit done = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  task automatic cfg_wr(input logic [CFG_AW-1:0] a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic cfg_rd(input logic [CFG_AW-1:0] a, output logic [31:0] d);
    @(negedge clk); cfg_addr = a;
    @(negedge clk); d = cfg_rdata;
  endtask

  // Runs one access; counts address and strobe cycles, words and bus errors.
  task automatic access(input int cs, input logic [AW-1:0] a, input bit we,
                        input logic [31:0] wd, input int rel_k,
                        output int ac, output int sc, output int nw, output bit ok);
    @(negedge clk);
    req_valid = 1'b1; req_cs = CSW'(cs); req_addr = a; req_we = we; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    ac = 0; sc = 0; nw = 0; ok = 1;
    for (int i = 0; i < 300; i++) begin
      if (rd_valid) begin
        if (we || rd_data != (32'hA500_0000 | {8'h00, a + AW'(4 * nw)})) ok = 0;
        nw++;
      end
      if (mem_cs_n == '1) break;
      if (mem_cs_n != ~(NCS'(1) << cs) || req_ready) ok = 0;
      if (!mem_rd_n && !mem_wr_n) ok = 0;
      if (!mem_rd_n || !mem_wr_n) begin
        sc++;
        if (we && (mem_dout != wd || mem_addr != a)) ok = 0;
        if (!we && !mem_wr_n) ok = 0;
      end else begin
        ac++;
      end
      if (rel_k > 0 && ac == rel_k) mem_rdy = 1'b1;
      if (i == 299) ok = 0;
      @(negedge clk);
    end
  endtask

  function automatic logic [31:0] tword(int fra, int ra, int racc, int wacc);
    return {16'd0, 4'(wacc), 4'(racc), 4'(ra), 4'(fra)};
  endfunction

  initial begin
    logic [31:0] rv;
    int ac, sc, nw;
    bit ok;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk(mem_cs_n == '1 && mem_rd_n && mem_wr_n, "R10", "reset bus idle", int'(mem_cs_n), 7);
    chk(req_ready && !rd_valid, "R10", "reset ready", int'(req_ready), 1);

    // R1 reset values of all six words
    for (int w = 0; w < 6; w++) begin
      cfg_rd(CFG_AW'(w * 4), rv);
      chk(rv == 0, "R1", "reset word", rv, 0);
    end
    // R2 masking
    cfg_wr(5'h00, 32'hFFFF_FFFF); cfg_rd(5'h00, rv);
    chk(rv == 32'h63, "R2", "mode mask", rv, 32'h63);
    cfg_wr(5'h04, 32'hFFFF_FFFF); cfg_rd(5'h04, rv);
    chk(rv == 32'hFFFF, "R2", "timing mask", rv, 32'hFFFF);
    // R3 misaligned and unmapped writes
    cfg_wr(5'h09, 32'h60); cfg_rd(5'h08, rv);
    chk(rv == 0, "R3", "misaligned write", rv, 0);
    cfg_wr(5'h0E, 32'h1234); cfg_rd(5'h0C, rv);
    chk(rv == 0, "R3", "misaligned timing write", rv, 0);
    cfg_wr(5'h18, 32'h60); cfg_rd(5'h18, rv);
    chk(rv == 0, "R3", "unmapped offset", rv, 0);
    cfg_rd(5'h10, rv);
    chk(rv == 0, "R3", "unmapped write leak", rv, 0);
    // R1 per-select placement
    for (int c = 0; c < NCS; c++) begin
      cfg_wr(CFG_AW'(c * 8), 32'(c + 1));
      cfg_wr(CFG_AW'(c * 8 + 4), 32'(16'h1111 * (c + 1)));
    end
    for (int c = 0; c < NCS; c++) begin
      cfg_rd(CFG_AW'(c * 8), rv);
      chk(rv == 32'(c + 1), "R1", "mode placement", rv, c + 1);
      cfg_rd(CFG_AW'(c * 8 + 4), rv);
      chk(rv == 32'(16'h1111 * (c + 1)), "R1", "timing placement", rv, 16'h1111 * (c + 1));
    end

    // R4 single reads
    for (int c = 0; c < NCS; c++) begin
      cfg_wr(CFG_AW'(c * 8), 32'h0);
      for (int ra = 0; ra < 3; ra++)
        for (int rc = 0; rc < 4; rc++) begin
          cfg_wr(CFG_AW'(c * 8 + 4), tword(3, ra, rc, 1));
          access(c, AW'(24'h100 + 16 * ra + 4 * rc), 1'b0, 0, 0, ac, sc, nw, ok);
          chk(ac == ra + 1, "R4", "read addr phase", ac, ra + 1);
          chk(sc == rc + 1, "R4", "read strobe", sc, rc + 1);
          chk(nw == 1 && ok, "R4", "read word/data (R10 bus)", nw, 1);
        end
    end

    // R5 writes, page bit set but irrelevant
    cfg_wr(5'h08, 32'h20);
    for (int ra = 0; ra < 3; ra++)
      for (int wc = 0; wc < 3; wc++) begin
        cfg_wr(5'h0C, tword(2, ra, 1, wc));
        access(1, AW'(24'h2000 + 4 * wc), 1'b1, 32'hC0DE_0000 + 32'(ra * 16 + wc), 0, ac, sc, nw, ok);
        chk(ac == ra + 1, "R5", "write addr phase", ac, ra + 1);
        chk(sc == wc + 1, "R5", "write strobe", sc, wc + 1);
        chk(nw == 0 && ok, "R5", "write bus values", nw, 0);
      end

    // R6 page bursts
    cfg_wr(5'h10, 32'h20);
    for (int fr = 0; fr < 3; fr++)
      for (int rc = 0; rc < 3; rc++)
        for (int k = 0; k < 4; k++) begin
          cfg_wr(5'h14, tword(fr, 0, rc, 0));
          access(2, AW'(24'h3440 + 4 * k), 1'b0, 0, 0, ac, sc, nw, ok);
          chk(ac == fr + 1, "R6", "page first addr phase", ac, fr + 1);
          chk(sc == (4 - k) * (rc + 1), "R6", "page strobe total", sc, (4 - k) * (rc + 1));
          chk(nw == 4 - k && ok, "R6", "page words/data", nw, 4 - k);
        end

    // R7 page fallback
    for (int ra = 1; ra < 3; ra++) begin
      cfg_wr(5'h14, tword(3, ra, 1, 0));
      access(2, AW'(24'h3440), 1'b0, 0, 0, ac, sc, nw, ok);
      chk(ac == ra + 1 && sc == 2, "R7", "fallback timing", ac, ra + 1);
      chk(nw == 1 && ok, "R7", "fallback single word", nw, 1);
    end

    // R8 ready mode off, ready held low
    cfg_wr(5'h00, 32'h0);
    mem_rdy = 1'b0;
    repeat (4) @(negedge clk);
    for (int ra = 0; ra < 3; ra++) begin
      cfg_wr(5'h04, tword(0, ra, 1, 1));
      access(0, AW'(24'h500), 1'b0, 0, 0, ac, sc, nw, ok);
      chk(ac == ra + 1 && sc == 2 && nw == 1 && ok, "R8", "ready ignored read", ac, ra + 1);
      access(0, AW'(24'h504), 1'b1, 32'h5A5A, 0, ac, sc, nw, ok);
      chk(ac == ra + 1 && sc == 2 && ok, "R8", "ready ignored write", ac, ra + 1);
    end

    // R9 ready mode on
    cfg_wr(5'h00, 32'h40);
    mem_rdy = 1'b1;
    repeat (4) @(negedge clk);
    for (int ra = 0; ra < 3; ra++) begin
      cfg_wr(5'h04, tword(0, ra, 2, 2));
      access(0, AW'(24'h600), 1'b0, 0, 0, ac, sc, nw, ok);
      chk(ac == ra + 1 && sc == 3 && nw == 1 && ok, "R9", "ready high read", ac, ra + 1);
    end
    for (int ra = 0; ra < 2; ra++)
      for (int w = 0; w < 2; w++) begin
        cfg_wr(5'h04, tword(0, ra, 2, 2));
        mem_rdy = 1'b0;
        repeat (4) @(negedge clk);
        access(0, AW'(24'h700), w[0], 32'h0BAD_F00D, 10, ac, sc, nw, ok);
        chk(ac >= 10 && ac <= 10 + ra + 3, "R9", "stall length", ac, 10 + ra + 2);
        chk(sc == 3 && ok && nw == (w == 0 ? 1 : 0), "R9", "after stall strobe", sc, 3);
      end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule